// File: doc/BRIEF.md
# Decimating Complex FIR with Time-Shared MAC

This block is the final decimating filter of a receive channel, placed after a fifth-order CIC stage. It accepts complex samples with a valid strobe. Each accepted sample is written into a circular sample buffer. After every D accepted samples, the block computes one complex output. The output is the sum of products between the newest N samples and N programmable 20-bit coefficients.

A single multiply-accumulate unit does all the arithmetic. It runs one product per clock, the I product of a tap first and then its Q product, so an output takes 2N cycles of arithmetic. The accumulated sums are rounded and saturated to 16 bits. Each result appears on the output port as a one-cycle valid pulse.

Coefficients, tap count and decimation factor are loaded through a control port while the filter is disabled. If the next output falls due before the current one is finished, that output is dropped and a sticky overrun flag is raised.

Top module: `rcf_decim_fir`

## Requirements
- R1: A coefficient write (`cw_we`=1 at a clock edge) stores `cw_data` at tap index `cw_addr` only when `en`=0 and `cw_addr` < MAX_TAPS (160). A write made while `en`=1 changes no later output.
- R2: While `en`=0, every clock captures the tap count N = `cfg_taps_m1`+1, clamped to MAX_TAPS (160), and the decimation factor D = `cfg_dec_m1`+1 (1 to 256). While `en`=1 both values are held, and changes on the config inputs have no effect.
- R3: A sample is accepted when `in_valid`=1 and `en`=1 at a clock edge. Every D-th accepted sample since the filter was enabled starts one output. Samples presented while `en`=0 are ignored.
- R4: For a started output, with x[0] the sample that started it, out_i is the sum over k=0..N-1 of c[k]·x_i[-k]. Out_q uses the same coefficients on the Q samples. Samples older than the first one accepted since enabling count as zero. All values are two's complement.
- R5: Each sum is rounded as (sum + 2^18) >>> 19 (arithmetic shift) and then saturated to the 16-bit range −32768..32767.
- R6: `out_valid` is a one-cycle pulse. It is high right after the (2N+1)-th rising edge following the edge that accepted the starting sample. Between pulses `out_i` and `out_q` hold their last values.
- R7: If a new output is started while the 2N arithmetic cycles of the previous output are still running, the new start is dropped and `overrun` is set. `overrun` then stays 1 until `overrun_clr` is high at an edge, and it can never be set while `en`=0.
- R8: Taking `en` low clears the sample history and the decimation count, and aborts any output in progress, so no pulse follows.
- R9: After reset, `out_valid`, `overrun`, `out_i` and `out_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Filter enable; low = configuration state |
| cfg_taps_m1 | input | 8 | Tap count minus one |
| cfg_dec_m1 | input | 8 | Decimation factor minus one |
| cw_we | input | 1 | Coefficient write strobe |
| cw_addr | input | 8 | Coefficient tap index |
| cw_data | input | 20 | Coefficient value, signed |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input I, signed |
| in_q | input | 16 | Input Q, signed |
| out_valid | output | 1 | Output strobe, one cycle |
| out_i | output | 16 | Output I, signed |
| out_q | output | 16 | Output Q, signed |
| overrun | output | 1 | Sticky flag: an output was dropped |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
The only timed result is the output pulse. It is due exactly 2N+1 edges after the edge that accepts the D-th sample, so 9 edges for four taps, 3 for one tap and 321 for the clamped 160-tap case. When the driver presents a starting sample, it records the cycle count of the accepting edge plus 2N+1 together with the modelled values. The monitor samples on falling edges and compares both the arrival cycle and the data. An entry that is still queued after its due cycle counts as a missed output. The overrun flag and aborted outputs are checked a fixed number of idle cycles after the stimulus, which is well beyond the longest 2N+1 window in use.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MAC  = 2'd1,
      ST_DONE = 2'd2
   } rcf_state_e;
endpackage

// File: rtl/rcf_coef_ram.sv
module rcf_coef_ram #(
   parameter int CW    = 20,
   parameter int DEPTH = 160,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [CW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [CW-1:0] rdata
);
   localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];
   logic [CW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && ({1'b0, waddr} < DEPTH_V)) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rcf_data_ram.sv
module rcf_data_ram #(
   parameter int W     = 32,
   parameter int DEPTH = 320,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata,
   output logic [AW-1:0] wptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         wptr <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wptr] <= wdata;
         wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rcf_mac.sv
module rcf_mac #(
   parameter int CW   = 20,
   parameter int DW   = 16,
   parameter int ACCW = 44
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   step,
   input  logic                   sel_q,
   input  logic [CW-1:0]          coef,
   input  logic [DW-1:0]          d_i,
   input  logic [DW-1:0]          d_q,
   output logic signed [ACCW-1:0] acc_i,
   output logic signed [ACCW-1:0] acc_q
);
   localparam int PW = CW + DW;
   logic signed [PW-1:0]   prod;
   logic signed [ACCW-1:0] prod_x;

   assign prod   = $signed(coef) * $signed(sel_q ? d_q : d_i);
   assign prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_i <= '0;
         acc_q <= '0;
      end else if (clr) begin
         acc_i <= '0;
         acc_q <= '0;
      end else if (step) begin
         if (sel_q) acc_q <= acc_q + prod_x;
         else       acc_i <= acc_i + prod_x;
      end
   end
endmodule

// File: rtl/rcf_round.sv
module rcf_round #(
   parameter int ACCW     = 44,
   parameter int OW       = 16,
   parameter int SHIFT    = 19,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic signed [ACCW-1:0] acc,
   output logic [OW-1:0]          y
);
   localparam logic signed [ACCW:0] HALF =
      {{(ACCW+1-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
   localparam logic signed [ACCW:0] MAXV =
      {{(ACCW+1-OW){1'b0}}, 1'b0, {(OW-1){1'b1}}};
   localparam logic signed [ACCW:0] MINV =
      {{(ACCW+2-OW){1'b1}}, {(OW-1){1'b0}}};

   logic signed [ACCW:0] ext, biased, shifted;
   assign ext = {acc[ACCW-1], acc};

   generate
      if (ROUND_EN) begin : g_round
         assign biased = ext + HALF;
      end else begin : g_trunc
         assign biased = ext;
      end
   endgenerate

   assign shifted = biased >>> SHIFT;

   always_comb begin
      if (shifted > MAXV)      y = MAXV[OW-1:0];
      else if (shifted < MINV) y = MINV[OW-1:0];
      else                     y = shifted[OW-1:0];
   end
endmodule

// File: rtl/rcf_decim_fir.sv
module rcf_decim_fir #(
   parameter int DW        = 16,
   parameter int CW        = 20,
   parameter int OW        = 16,
   parameter int MAX_TAPS  = 160,
   parameter int MAX_DEC   = 256,
   parameter int OUT_SHIFT = 19,
   parameter bit ROUND_EN  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic [$clog2(MAX_TAPS)-1:0] cfg_taps_m1,
   input  logic [$clog2(MAX_DEC)-1:0]  cfg_dec_m1,
   input  logic                        cw_we,
   input  logic [$clog2(MAX_TAPS)-1:0] cw_addr,
   input  logic [CW-1:0]               cw_data,
   input  logic                        in_valid,
   input  logic [DW-1:0]               in_i,
   input  logic [DW-1:0]               in_q,
   output logic                        out_valid,
   output logic [OW-1:0]               out_i,
   output logic [OW-1:0]               out_q,
   output logic                        overrun,
   input  logic                        overrun_clr
);
   import rcf_pkg::*;

   localparam int TAW    = $clog2(MAX_TAPS);
   localparam int DECW   = $clog2(MAX_DEC);
   localparam int DDEPTH = 2 * MAX_TAPS;
   localparam int DAW    = $clog2(DDEPTH);
   localparam int ACCW   = CW + DW + 8;
   localparam int TM     = MAX_TAPS - 1;
   localparam logic [TAW-1:0] TMAX = TM[TAW-1:0];
   localparam logic [DAW:0]   DD_V = DDEPTH[DAW:0];

   generate
      if (MAX_TAPS < 2) begin : g_bad_taps
         $error("MAX_TAPS must be at least 2");
      end
      if ((1 << DECW) != MAX_DEC) begin : g_bad_dec
         $error("MAX_DEC must be a power of two");
      end
      if (OUT_SHIFT < 1 || OUT_SHIFT > ACCW - OW) begin : g_bad_shift
         $error("OUT_SHIFT out of range");
      end
   endgenerate

   logic [TAW-1:0]  taps_r, k;
   logic [DECW-1:0] dec_r, dcnt;
   logic [DAW-1:0]  base, wptr, rd_addr;
   logic [DAW:0]    addr_w;
   rcf_state_e      st;
   logic            sel_q, accept, trig, start;
   logic [CW-1:0]   coef;
   logic [2*DW-1:0] samp;
   logic signed [ACCW-1:0] acc_i, acc_q;
   logic [OW-1:0]   rnd_i, rnd_q;

   assign accept = in_valid & en;
   assign trig   = accept && (dcnt == dec_r);
   assign start  = trig && (st != ST_MAC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps_r <= '0;
         dec_r  <= '0;
      end else if (!en) begin
         taps_r <= (cfg_taps_m1 > TMAX) ? TMAX : cfg_taps_m1;
         dec_r  <= cfg_dec_m1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dcnt <= '0;
      else if (!en)    dcnt <= '0;
      else if (accept) dcnt <= trig ? '0 : dcnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; k <= '0; sel_q <= 1'b0; base <= '0;
      end else if (!en) begin
         st <= ST_IDLE; sel_q <= 1'b0;
      end else if (start) begin
         st <= ST_MAC; k <= taps_r; sel_q <= 1'b0; base <= wptr;
      end else if (st == ST_MAC) begin
         sel_q <= ~sel_q;
         if (sel_q) begin
            if (k == '0) st <= ST_DONE;
            else         k  <= k - 1'b1;
         end
      end else if (st == ST_DONE) begin
         st <= ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overrun <= 1'b0;
      else        overrun <= (trig && st == ST_MAC) | (overrun & ~overrun_clr);
   end

   // oldest tap first: newest sample read last, so buffer writes never overtake reads
   assign addr_w  = {1'b0, base} + DD_V - {{(DAW+1-TAW){1'b0}}, k};
   assign rd_addr = (addr_w >= DD_V) ? DAW'(addr_w - DD_V) : addr_w[DAW-1:0];

   rcf_coef_ram #(.CW(CW), .DEPTH(MAX_TAPS), .AW(TAW)) u_coef (
      .clk(clk), .rst_n(rst_n), .we(cw_we & ~en), .waddr(cw_addr),
      .wdata(cw_data), .raddr(k), .rdata(coef));

   rcf_data_ram #(.W(2*DW), .DEPTH(DDEPTH), .AW(DAW)) u_data (
      .clk(clk), .rst_n(rst_n), .clr(~en), .we(accept), .wdata({in_q, in_i}),
      .raddr(rd_addr), .rdata(samp), .wptr(wptr));

   rcf_mac #(.CW(CW), .DW(DW), .ACCW(ACCW)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(start), .step(en && st == ST_MAC),
      .sel_q(sel_q), .coef(coef), .d_i(samp[DW-1:0]), .d_q(samp[2*DW-1:DW]),
      .acc_i(acc_i), .acc_q(acc_q));

   rcf_round #(.ACCW(ACCW), .OW(OW), .SHIFT(OUT_SHIFT), .ROUND_EN(ROUND_EN)) u_rnd_i (
      .acc(acc_i), .y(rnd_i));
   rcf_round #(.ACCW(ACCW), .OW(OW), .SHIFT(OUT_SHIFT), .ROUND_EN(ROUND_EN)) u_rnd_q (
      .acc(acc_q), .y(rnd_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0; out_i <= '0; out_q <= '0;
      end else begin
         out_valid <= en && (st == ST_DONE);
         if (en && st == ST_DONE) begin
            out_i <= rnd_i;
            out_q <= rnd_q;
         end
      end
   end
endmodule

// File: rtl/rcf_decim_fir_chk.sv
module rcf_decim_fir_chk #(
   parameter int OW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          out_valid,
   input logic [OW-1:0] out_i,
   input logic [OW-1:0] out_q,
   input logic          overrun,
   input logic          overrun_clr
);
   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));

   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !out_valid);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !overrun_clr) |=> overrun);

   p_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !overrun) |=> !overrun);

   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_clr && !en) |=> !overrun);
endmodule

bind rcf_decim_fir rcf_decim_fir_chk #(.OW(OW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .out_valid(out_valid),
   .out_i(out_i), .out_q(out_q), .overrun(overrun), .overrun_clr(overrun_clr));

// File: tb/rcf_decim_fir_test.sv
module rcf_decim_fir_test;
   localparam int MT = 160;

   logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
   logic [7:0]  cfg_taps_m1 = '0, cfg_dec_m1 = '0, cw_addr = '0;
   logic        cw_we = 1'b0, in_valid = 1'b0, overrun_clr = 1'b0;
   logic [19:0] cw_data = '0;
   logic [15:0] in_i = '0, in_q = '0;
   logic        out_valid, overrun;
   logic [15:0] out_i, out_q;

   rcf_decim_fir uut (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_taps_m1(cfg_taps_m1),
      .cfg_dec_m1(cfg_dec_m1), .cw_we(cw_we), .cw_addr(cw_addr), .cw_data(cw_data),
      .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
      .out_i(out_i), .out_q(out_q), .overrun(overrun), .overrun_clr(overrun_clr));

   always #10 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0, outs_seen = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference model state
   longint coef_m [MT];
   int     hist_i[$], hist_q[$];
   int     n_m = 1, d_m = 1, cnt_m = 0;
   bit     en_m = 1'b0, sb_on = 1'b1;
   longint exp_i[$], exp_q[$];
   int     exp_c[$];

   task automatic check(string req, longint act, longint expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic longint rnd_sat(longint s);
      longint r = (s + (64'sd1 <<< 18)) >>> 19;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic set_en(bit v);
      en = v; en_m = v;
      if (!v) begin hist_i.delete(); hist_q.delete(); cnt_m = 0; end
      @(negedge clk);
   endtask

   task automatic do_cfg(int taps_m1, int dec_m1);
      cfg_taps_m1 = 8'(taps_m1); cfg_dec_m1 = 8'(dec_m1);
      if (!en_m) begin
         n_m = (taps_m1 + 1 > MT) ? MT : taps_m1 + 1;
         d_m = dec_m1 + 1;
      end
      @(negedge clk);
   endtask

   task automatic wcoef(int addr, int val);
      cw_we = 1'b1; cw_addr = 8'(addr); cw_data = 20'(val);
      if (!en_m && addr < MT) coef_m[addr] = longint'(val);
      @(negedge clk);
      cw_we = 1'b0;
   endtask

   // driver: present one sample, push the expected output when it starts one
   task automatic send(int vi, int vq);
      in_valid = 1'b1; in_i = 16'(vi); in_q = 16'(vq);
      if (en_m) begin
         hist_i.push_back(vi); hist_q.push_back(vq);
         cnt_m++;
         if (cnt_m == d_m) begin
            longint si = 0, sq = 0;
            cnt_m = 0;
            for (int k = 0; k < n_m; k++) begin
               int idx = hist_i.size() - 1 - k;
               if (idx >= 0) begin
                  si += coef_m[k] * longint'(hist_i[idx]);
                  sq += coef_m[k] * longint'(hist_q[idx]);
               end
            end
            if (sb_on) begin
               exp_i.push_back(rnd_sat(si));
               exp_q.push_back(rnd_sat(sq));
               exp_c.push_back(cyc + 1 + 2 * n_m + 1);
            end
         end
      end
      @(negedge clk);
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   function automatic int rv(int span);
      return int'($urandom_range(0, 2 * span)) - span;
   endfunction

   // monitor: compare value and arrival cycle of every output pulse
   always @(negedge clk) begin
      if (out_valid) begin
         outs_seen++;
         if (sb_on) begin
            if (exp_c.size() == 0) begin
               check("R3 unexpected output", 1, 0);
            end else begin
               check("R6 output cycle", cyc, exp_c.pop_front());
               check("R4 R5 out_i", longint'($signed(out_i)), exp_i.pop_front());
               check("R4 R5 out_q", longint'($signed(out_q)), exp_q.pop_front());
            end
         end
      end else if (sb_on && exp_c.size() != 0 && exp_c[0] < cyc) begin
         check("R6 missing output", cyc, exp_c.pop_front());
         void'(exp_i.pop_front()); void'(exp_q.pop_front());
      end
   end

   initial begin
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seen;
      for (int i = 0; i < MT; i++) coef_m[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check("R9 out_valid", out_valid, 0);
      check("R9 overrun", overrun, 0);
      check("R9 out_i", out_i, 0);
      check("R9 out_q", out_q, 0);

      // R2 R4 four taps, decimate by ten
      do_cfg(3, 9);
      wcoef(0, 262144); wcoef(1, -100000); wcoef(2, 300000); wcoef(3, 52428);
      // R3 samples while disabled are ignored
      for (int i = 0; i < 5; i++) send(30000, -30000);
      idle(1);
      set_en(1'b1);
      for (int i = 0; i < 45; i++) send(rv(20000), rv(20000));
      for (int i = 0; i < 20; i++) begin send(rv(30000), rv(30000)); idle(2); end
      idle(15);

      // R1 coefficient write while enabled has no effect
      wcoef(0, -524288);
      // R2 config change while enabled has no effect
      do_cfg(0, 2);
      for (int i = 0; i < 30; i++) send(rv(25000), rv(25000));
      idle(15);

      // R8 abort on disable
      do_cfg(3, 9);
      set_en(1'b0);
      set_en(1'b1);
      sb_on = 1'b0;
      for (int i = 0; i < 10; i++) send(20000, 20000);
      idle(0);
      seen = outs_seen;
      set_en(1'b0);
      idle(20);
      check("R8 no pulse after abort", outs_seen, seen);
      sb_on = 1'b1;
      // R8 history cleared: restart sees zeros before new samples
      set_en(1'b1);
      for (int i = 0; i < 25; i++) send(rv(20000), rv(20000));
      idle(15);

      // R2 boundary: one tap, decimate by one
      set_en(1'b0);
      do_cfg(0, 0);
      wcoef(0, 524287);
      set_en(1'b1);
      for (int i = 0; i < 6; i++) begin send(rv(32000), rv(32000)); idle(3); end
      idle(5);

      // R5 saturation both ways
      set_en(1'b0);
      do_cfg(3, 9);
      for (int i = 0; i < 4; i++) wcoef(i, 524287);
      set_en(1'b1);
      for (int i = 0; i < 20; i++) send(32000, -32000);
      idle(15);

      // R2 clamp to 160 taps, decimate by 256, buffer wrap
      set_en(1'b0);
      do_cfg(255, 255);
      for (int i = 0; i < MT; i++) wcoef(i, rv(2000));
      set_en(1'b1);
      for (int i = 0; i < 600; i++) begin send(rv(20000), rv(20000)); idle(1); end
      idle(400);
      check("R7 no false overrun", overrun, 0);

      // R7 overrun: eight taps, decimate by four
      set_en(1'b0);
      do_cfg(7, 3);
      set_en(1'b1);
      sb_on = 1'b0;
      for (int i = 0; i < 12; i++) send(1000, 1000);
      idle(40);
      check("R7 overrun set", overrun, 1);
      idle(5);
      check("R7 overrun sticky", overrun, 1);
      overrun_clr = 1'b1;
      @(negedge clk);
      overrun_clr = 1'b0;
      check("R7 overrun cleared", overrun, 0);
      set_en(1'b0);
      sb_on = 1'b1;
      idle(5);

      check("R6 all outputs delivered", exp_c.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule